// File: doc/BRIEF.md
# I2C Slave Byte Engine with Selectable Clock Stretch

This block is the target side of a two-wire serial bus. It watches the clock and data lines through two-flop synchronisers and detects start and stop conditions. It shifts in the address byte and compares it with one fixed 7-bit address. After a match it moves whole bytes in either direction. Both lines are open-drain: the block only pulls a line low or lets it go, and the bus pull-ups supply the high level.

At each byte the block can hold the clock line low. This gives the host logic time to read a received byte, decide on the acknowledge, or supply the next byte to transmit. A control input picks the hold point for received bytes: just after the eighth clock falls, before the acknowledge slot, or just after the ninth clock falls. Each hold point raises a one-cycle interrupt.

The host ends a hold in one of two ways: a data write, or a one-shot release command. While the block is transmitting, these two are not the same. A data write loads the next byte and transmission carries on. The release command drops the transmit direction, and the block stops driving data.

Top module: `i2c_stretch_slave`

## Requirements
- R1: After reset, both line pulls are off, and `tx_mode`, `irq`, `start_seen`, `stop_seen`, `ack_seen` and `rx_byte` are all zero.
- R2: Start and stop are detected while the clock line is high. SDA falling is a start: it sets `start_seen` and clears `stop_seen`. SDA rising is a stop: it sets `stop_seen`, clears `start_seen` and `tx_mode`, and raises `irq` for one cycle.
- R3: The first byte after a start is the address. Its seven upper bits are sent MSB first, and its last bit is the direction (1 = the master reads). If the upper bits equal `OWN_ADDR` (default 7'h2A), the block pulls SDA low in the ninth clock. Otherwise it does not acknowledge, raises no interrupt and ignores the bus until the next start.
- R4: With `wait9` = 0, for each received byte, including a write address, SCL is held low from the eighth falling clock edge onward. `rx_byte` then holds the byte. The acknowledge driven in the ninth clock is taken from `ack_en` at the moment of release (1 = pull SDA low).
- R5: With `wait9` = 1, a received byte takes its acknowledge from `ack_en` at the eighth falling edge. SCL is held low from the ninth falling edge onward.
- R6: A one-cycle `wr_data` or `rel_cmd` during a hold frees SCL within three cycles, whatever the value written (0xFF included).
- R7: After a read address is acknowledged, SCL is always held low after the ninth clock, whatever `wait9` is. A data write during that hold loads the byte, which is sent MSB first. The block holds again after each data byte that the master acknowledges.
- R8: While transmitting, `ack_seen` takes the inverse of SDA at the ninth rising clock edge (1 = ACK, 0 = NACK). After a NACK the block raises no hold and leaves SDA released until the next start.
- R9: A `rel_cmd` without `wr_data` during a transmit hold clears `tx_mode`, and the block stops driving SDA.
- R10: If `wr_data` and `rel_cmd` arrive in the same cycle during a transmit hold, the write wins: the byte is sent and `tx_mode` stays 1.
- R11: `irq` is high for exactly one cycle at every hold point and at every stop.
- R12: The block changes its SDA pull only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Clock line level seen at the pin |
| sda_in | input | 1 | Data line level seen at the pin |
| scl_pull | output | 1 | 1 pulls the clock line low |
| sda_pull | output | 1 | 1 pulls the data line low |
| wr_data | input | 1 | One-cycle data write strobe |
| wdata | input | 8 | Byte written with `wr_data` |
| rel_cmd | input | 1 | One-cycle hold release command |
| ack_en | input | 1 | 1 acknowledges received bytes |
| wait9 | input | 1 | Hold point for received bytes: 0 after clock 8, 1 after clock 9 |
| rx_byte | output | 8 | Last received data byte |
| tx_mode | output | 1 | 1 while the block is transmitting |
| ack_seen | output | 1 | Acknowledge from the master in transmit, 1 = ACK |
| start_seen | output | 1 | Set by start, cleared by stop |
| stop_seen | output | 1 | Set by stop, cleared by start |
| irq | output | 1 | One-cycle pulse at each hold point and stop |

## Verification
A data write and a release command can arrive in the same cycle during a transmit hold, and the two ask for opposite outcomes: one keeps the transmit direction, the other drops it. The bench drives both strobes on one clock during a read. It judges the result by the byte the modelled master reads next and by `tx_mode`, which must still be 1. Separate runs of each release method alone confirm that the outcome of the collision is the write's, not a blend of the two.

// File: rtl/i2c_stretch_slave.sv
module i2c_stretch_slave #(
  parameter logic [6:0] OWN_ADDR = 7'h2A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_pull,
  output logic       sda_pull,
  input  logic       wr_data,
  input  logic [7:0] wdata,
  input  logic       rel_cmd,
  input  logic       ack_en,
  input  logic       wait9,
  output logic [7:0] rx_byte,
  output logic       tx_mode,
  output logic       ack_seen,
  output logic       start_seen,
  output logic       stop_seen,
  output logic       irq
);

  logic       scl_m, scl_s, scl_q, sda_m, sda_s, sda_q;
  logic       active, addr_ph, txv, hold, hold_q, ackdrv;
  logic [3:0] rc, slot;
  logic [7:0] shreg, txsh;

  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire release_now = hold & (wr_data | rel_cmd);

  assign scl_pull = hold_q;
  assign sda_pull = ackdrv | (txv & tx_mode & ~txsh[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_q <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_q <= 1'b1;
      active <= 1'b0; addr_ph <= 1'b0; txv <= 1'b0;
      hold <= 1'b0; hold_q <= 1'b0; ackdrv <= 1'b0;
      rc <= 4'd0; slot <= 4'd0; shreg <= 8'd0; txsh <= 8'd0;
      rx_byte <= 8'd0; tx_mode <= 1'b0; ack_seen <= 1'b0;
      start_seen <= 1'b0; stop_seen <= 1'b0; irq <= 1'b0;
    end else begin
      scl_m <= scl_in; scl_s <= scl_m; scl_q <= scl_s;
      sda_m <= sda_in; sda_s <= sda_m; sda_q <= sda_s;
      irq <= 1'b0;
      hold_q <= hold;
      if (start_det) begin
        active <= 1'b1; addr_ph <= 1'b1; rc <= 4'd0; slot <= 4'd0;
        tx_mode <= 1'b0; txv <= 1'b0; hold <= 1'b0; ackdrv <= 1'b0;
        start_seen <= 1'b1; stop_seen <= 1'b0;
      end else if (stop_det) begin
        active <= 1'b0; tx_mode <= 1'b0; txv <= 1'b0; hold <= 1'b0;
        ackdrv <= 1'b0; stop_seen <= 1'b1; start_seen <= 1'b0; irq <= 1'b1;
      end else begin
        if (release_now) begin
          hold <= 1'b0;
          if (slot == 4'd8) ackdrv <= addr_ph | ack_en;
          else if (tx_mode) begin
            if (wr_data) begin
              txsh <= wdata;
              txv  <= 1'b1;
            end else begin
              tx_mode <= 1'b0;
            end
          end
        end
        if (active && scl_rise) begin
          if (rc < 4'd8) begin
            shreg <= {shreg[6:0], sda_s};
            rc    <= rc + 4'd1;
          end else if (rc == 4'd8) begin
            rc <= 4'd9;
            if (tx_mode && !addr_ph) ack_seen <= ~sda_s;
          end
        end
        if (active && scl_fall) begin
          slot <= (rc == 4'd9) ? 4'd0 : rc;
          if (tx_mode && rc >= 4'd1 && rc <= 4'd7) txsh <= {txsh[6:0], 1'b0};
          if (rc == 4'd8) begin
            txv <= 1'b0;
            if (addr_ph) begin
              if (shreg[7:1] == OWN_ADDR) begin
                tx_mode <= shreg[0];
                if (!shreg[0] && !wait9) begin
                  hold <= 1'b1;
                  irq  <= 1'b1;
                end else begin
                  ackdrv <= 1'b1;
                end
              end else begin
                active <= 1'b0;
              end
            end else if (!tx_mode) begin
              rx_byte <= shreg;
              if (!wait9) begin
                hold <= 1'b1;
                irq  <= 1'b1;
              end else begin
                ackdrv <= ack_en;
              end
            end
          end
          if (rc == 4'd9) begin
            rc <= 4'd0; ackdrv <= 1'b0; addr_ph <= 1'b0;
            if (tx_mode) begin
              if (addr_ph || ack_seen) begin
                hold <= 1'b1;
                irq  <= 1'b1;
              end else begin
                active <= 1'b0;
              end
            end else if (wait9) begin
              hold <= 1'b1;
              irq  <= 1'b1;
            end
          end
        end
      end
    end
  end

  // R11
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R2
  stop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (stop_seen && !start_seen && irq && !tx_mode));

  // R6
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && scl_pull && !wr_data && !rel_cmd && !stop_det && !start_det) |=> scl_pull);

  // R6
  hold_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && scl_pull && (wr_data || rel_cmd) && !start_det && !stop_det) |=> ##1 !scl_pull);

  // R9
  rel_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && tx_mode && slot == 4'd0 && rel_cmd && !wr_data && !start_det && !stop_det) |=> (!tx_mode && !sda_pull));

  // R10
  both_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && tx_mode && slot == 4'd0 && rel_cmd && wr_data && !start_det && !stop_det) |=> tx_mode);

  // R12
  sda_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !$past(scl_s));

endmodule

// File: tb/i2c_stretch_slave_test.sv
module i2c_stretch_slave_test;
  localparam int HALF    = 150;
  localparam int STOP_SU = 150;
  localparam logic [6:0] ADR = 7'h2A;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, m_scl_oe, m_sda_oe, wr_data, rel_cmd, ack_en, wait9;
  logic [7:0] wdata;
  logic scl_pull, sda_pull, tx_mode, ack_seen, start_seen, stop_seen, irq;
  logic [7:0] rx_byte;
  logic scl, sda;
  assign scl = !(m_scl_oe || scl_pull);
  assign sda = !(m_sda_oe || sda_pull);

  i2c_stretch_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .wr_data(wr_data), .wdata(wdata),
    .rel_cmd(rel_cmd), .ack_en(ack_en), .wait9(wait9), .rx_byte(rx_byte),
    .tx_mode(tx_mode), .ack_seen(ack_seen), .start_seen(start_seen),
    .stop_seen(stop_seen), .irq(irq));

  int compared = 0, mismatched = 0, irq_cnt = 0, m_falls = 0;
  bit cmp_en = 0, exp_trc = 0, exp_std = 0, exp_spd = 0, done = 0;
  logic irq_prev = 0, sda_prev = 0;
  int q_pt[$], q_act[$], q_dat[$], q_ack[$], q_rx[$], q_ad[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int pt, input int act, input int dat, input int ackn, input int rx, input int ad);
    q_pt.push_back(pt); q_act.push_back(act); q_dat.push_back(dat);
    q_ack.push_back(ackn); q_rx.push_back(rx); q_ad.push_back(ad);
  endtask

  // reference model compared on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) begin
        irq_cnt++;
        chk(!irq_prev, "R11", "irq width", 1, 0);
      end
      if (sda_pull !== sda_prev) chk(scl == 1'b0, "R12", "scl during sda change", scl, 0);
      if (cmp_en) begin
        chk(tx_mode == exp_trc, "R9", "tx_mode", tx_mode, exp_trc);
        chk(start_seen == exp_std, "R2", "start_seen", start_seen, exp_std);
        chk(stop_seen == exp_spd, "R2", "stop_seen", stop_seen, exp_spd);
      end
    end
    irq_prev = irq;
    sda_prev = sda_pull;
  end

  // host side: serves each hold point
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && irq && !stop_seen) begin
        if (q_pt.size() == 0) begin
          chk(0, "R11", "unexpected hold", 1, 0);
          rel_cmd = 1; @(negedge clk); rel_cmd = 0;
        end else begin
          automatic int pt = q_pt.pop_front();
          automatic int act = q_act.pop_front();
          automatic int dat = q_dat.pop_front();
          automatic int ackn = q_ack.pop_front();
          automatic int rx = q_rx.pop_front();
          automatic int ad = q_ad.pop_front();
          automatic string tg = (pt == 8) ? "R4" : "R5";
          tick(40);
          chk(scl_pull == 1'b1 && scl == 1'b0, tg, "scl stretched", scl_pull, 1);
          chk((m_falls % 9) == (pt % 9), tg, "hold point", m_falls % 9, pt % 9);
          if (rx >= 0) chk(rx_byte == rx[7:0], "R4", "rx_byte", rx_byte, rx);
          if (ad >= 0) chk(ack_seen == ad[0], "R8", "ack_seen", ack_seen, ad);
          ack_en = ackn[0];
          if (act == 1 && exp_trc) cmp_en = 0;
          wr_data = (act != 1);
          rel_cmd = (act != 0);
          wdata = dat[7:0];
          @(negedge clk);
          wr_data = 0; rel_cmd = 0;
          tick(3);
          chk(scl_pull == 1'b0, "R6", "scl freed", scl_pull, 0);
          if (act == 1 && exp_trc) begin
            exp_trc = 0;
            chk(tx_mode == 1'b0, "R9", "tx_mode after release cmd", tx_mode, 0);
            chk(sda_pull == 1'b0, "R9", "sda released", sda_pull, 0);
            cmp_en = 1;
          end
          if (act == 2) chk(tx_mode == 1'b1, "R10", "tx_mode after both", tx_mode, 1);
        end
      end
    end
  end

  task automatic m_start();
    cmp_en = 0;
    m_sda_oe = 0; m_scl_oe = 0;
    tick(HALF);
    m_sda_oe = 1;
    tick(HALF);
    m_scl_oe = 1; m_falls = 0;
    tick(HALF / 2);
    exp_std = 1; exp_spd = 0; exp_trc = 0;
    cmp_en = 1;
  endtask

  task automatic m_bit(input bit v, output bit s);
    m_sda_oe = !v;
    tick(HALF);
    m_scl_oe = 0;
    while (scl == 1'b0) @(negedge clk);
    tick(HALF);
    s = sda;
    m_scl_oe = 1; m_falls++;
    tick(10);
  endtask

  task automatic m_wbyte(input logic [7:0] b, output bit nak);
    bit s;
    for (int i = 7; i >= 0; i--) m_bit(b[i], s);
    m_bit(1'b1, nak);
  endtask

  task automatic m_rbyte(input bit nak, output logic [7:0] d);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, s);
      d[i] = s;
    end
    m_bit(nak, s);
  endtask

  task automatic m_stop();
    int n0;
    m_sda_oe = 1;
    tick(HALF);
    m_scl_oe = 0;
    while (scl == 1'b0) @(negedge clk);
    tick(STOP_SU);
    n0 = irq_cnt;
    cmp_en = 0;
    m_sda_oe = 0;
    tick(HALF / 2);
    exp_spd = 1; exp_std = 0; exp_trc = 0;
    cmp_en = 1;
    chk(irq_cnt == n0 + 1, "R11", "stop irq count", irq_cnt - n0, 1);
    tick(HALF);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      chk(0, "R6", "watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] d;
    int n0;
    rst_n = 0; m_scl_oe = 0; m_sda_oe = 0; wr_data = 0; rel_cmd = 0;
    ack_en = 1; wait9 = 0; wdata = 8'h00;
    tick(10);
    chk(scl_pull == 0 && sda_pull == 0, "R1", "pulls at reset", {scl_pull, sda_pull}, 0);
    chk(tx_mode == 0 && irq == 0, "R1", "tx_mode/irq at reset", {tx_mode, irq}, 0);
    chk(start_seen == 0 && stop_seen == 0, "R1", "start/stop at reset", {start_seen, stop_seen}, 0);
    chk(ack_seen == 0 && rx_byte == 8'h00, "R1", "ack/rx at reset", rx_byte, 0);
    rst_n = 1;
    tick(10);
    cmp_en = 1;

    // hold after clock 8, acknowledge chosen at release
    wait9 = 0; ack_en = 1;
    m_start();
    push(8, 1, 0, 1, -1, -1);
    m_wbyte({ADR, 1'b0}, a);
    chk(a == 0, "R3", "write address ack", a, 0);
    push(8, 0, 8'hFF, 1, 8'h5A, -1);
    m_wbyte(8'h5A, a);
    chk(a == 0, "R4", "ack with ack_en=1", a, 0);
    push(8, 0, 8'hFF, 0, 8'hC3, -1);
    m_wbyte(8'hC3, a);
    chk(a == 1, "R4", "nack with ack_en=0 at release", a, 1);
    m_stop();

    // hold after clock 9, acknowledge taken at clock 8
    wait9 = 1; ack_en = 1;
    m_start();
    push(9, 1, 0, 1, -1, -1);
    m_wbyte({ADR, 1'b0}, a);
    chk(a == 0, "R3", "write address ack", a, 0);
    push(9, 0, 8'hFF, 0, 8'h96, -1);
    m_wbyte(8'h96, a);
    chk(a == 0, "R5", "ack from ack_en at clock 8", a, 0);
    push(9, 1, 0, 1, 8'h3C, -1);
    m_wbyte(8'h3C, a);
    chk(a == 1, "R5", "nack from ack_en at clock 8", a, 1);
    m_stop();

    // foreign address is ignored
    m_start();
    n0 = irq_cnt;
    m_wbyte({7'h15, 1'b0}, a);
    chk(a == 1, "R3", "foreign address nack", a, 1);
    m_wbyte(8'h00, a);
    chk(a == 1, "R3", "ignored byte nack", a, 1);
    chk(irq_cnt == n0, "R3", "no irq when unaddressed", irq_cnt - n0, 0);
    chk(rx_byte == 8'h3C, "R3", "rx_byte unchanged", rx_byte, 8'h3C);
    m_stop();

    // transmit, released by data writes, ends with NACK
    wait9 = 0;
    m_start();
    cmp_en = 0;
    push(9, 0, 8'hA5, 1, -1, -1);
    m_wbyte({ADR, 1'b1}, a);
    exp_trc = 1; cmp_en = 1;
    chk(a == 0, "R3", "read address ack", a, 0);
    push(9, 0, 8'h3C, 1, -1, 1);
    m_rbyte(1'b0, d);
    chk(d == 8'hA5, "R7", "first read byte", d, 8'hA5);
    n0 = irq_cnt;
    m_rbyte(1'b1, d);
    chk(d == 8'h3C, "R7", "second read byte", d, 8'h3C);
    chk(ack_seen == 0, "R8", "nack recorded", ack_seen, 0);
    m_rbyte(1'b1, d);
    chk(d == 8'hFF, "R8", "sda released after nack", d, 8'hFF);
    chk(irq_cnt == n0, "R8", "no hold after nack", irq_cnt - n0, 0);
    m_stop();

    // transmit hold ended by release command
    m_start();
    cmp_en = 0;
    push(9, 0, 8'h81, 1, -1, -1);
    m_wbyte({ADR, 1'b1}, a);
    exp_trc = 1; cmp_en = 1;
    push(9, 1, 0, 1, -1, 1);
    m_rbyte(1'b0, d);
    chk(d == 8'h81, "R7", "read byte before release cmd", d, 8'h81);
    m_stop();

    // write and release command in one cycle
    m_start();
    cmp_en = 0;
    push(9, 0, 8'h11, 1, -1, -1);
    m_wbyte({ADR, 1'b1}, a);
    exp_trc = 1; cmp_en = 1;
    push(9, 2, 8'h6E, 1, -1, 1);
    m_rbyte(1'b0, d);
    chk(d == 8'h11, "R7", "read byte", d, 8'h11);
    m_rbyte(1'b1, d);
    chk(d == 8'h6E, "R10", "byte sent after collision", d, 8'h6E);
    m_stop();

    chk(q_pt.size() == 0, "R11", "holds served", q_pt.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule